// File: doc/BRIEF.md
# Block Transform Load and Dump Sequencer

This block is the control sequencer for the workspace memory of a block-transform engine. When the active-low define input rises, the block captures a mode word from the auxiliary bus. It then waits for the input-enable pin to open a load. On each rising edge of the data-input strobe it writes one sample into an external workspace RAM, at addresses that climb from zero. When the block is full, it counts out a programmable number of clock cycles that stand in for the transform computation. After that it lowers a data-available flag, optionally after a further 24 output strobes. It then reads the results back out in the same ascending order, one per divided output strobe.

All strobes and control inputs are asynchronous to the system clock. Each is synchronised through two flip-flops and edge-detected inside the block. The strobes set the pace on both sides, so the sample stream has no back-pressure. The writer must not issue a strobe faster than the synchroniser can resolve: each level must last at least two clock periods. A strobe that reaches the block while no write or read is allowed is dropped, and no stall is signalled. The result buses are not part of this block. It drives only the tri-state enable for them.

Mode word fields on the auxiliary bus:

| Bits | Meaning | Encoding |
|------|---------|----------|
| [1:0] | Load-flag release | 00 = full block, 01 = half block, 10 = quarter block, 11 = full block |
| 2 | Input-enable role | 0 = gate, 1 = start |
| 3 | Output delay | 1 = delay data-available by 24 divided output strobes |
| [5:4] | Output-strobe divide ratio | 00 = 1, 01 = 2, 10 or 11 = 4 |

Top module: `xform_seq_ctrl`

## Requirements
- R1: While `define_n` is low, the outputs are held in reset: `load_busy`=0, `avail_n`=1, `wr_en`=0, `rd_en`=0, `bus_oe`=0. The mode word is taken from `aux_word` in the first clock after `define_n` rises.
- R2: In gate mode (mode bit 2 = 0), a low level on `in_en_n` opens a load. A rising edge of `din_stb` is written only while `in_en_n` is low. Strobes that arrive while `in_en_n` is high produce no `wr_en`.
- R3: In start mode (mode bit 2 = 1), a falling edge of `in_en_n` opens a load. Strobes that arrive before that edge produce no `wr_en`. Once the load is open, every `din_stb` rising edge is written, whatever level `in_en_n` then has.
- R4: Each accepted `din_stb` rising edge gives exactly one `wr_en` pulse. The `wr_addr` values run 0, 1, … BLOCK_LEN-1 with no gap or repeat.
- R5: `load_busy` goes high when a load opens. It falls after the Kth write, where K is BLOCK_LEN when mode bits [1:0] are 00, BLOCK_LEN/2 when they are 01, and BLOCK_LEN/4 when they are 10. Writing continues until the block is full.
- R6: `avail_n` stays high during loading and for COMPUTE_CYCLES clocks after the last write. It then goes low, provided mode bit 3 = 0.
- R7: When mode bit 3 = 1, `avail_n` goes low only after OUT_DELAY (24) divided output strobes have arrived following the compute phase.
- R8: `bus_oe` is high only while `avail_n` is low and `dump_en_n` is low. No `rd_en` occurs while `bus_oe` is low, and the dump waits for `dump_en_n` to fall.
- R9: Each divided output strobe taken while `bus_oe` is high gives one `rd_en` pulse. The `rd_addr` values run 0 … BLOCK_LEN-1. After the last read, `avail_n` returns high.
- R10: Mode bits [5:4] divide the `dout_stb` rising edges: 00 passes every edge, 01 passes every 2nd edge, 10 passes every 4th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| define_n | input | 1 | Active-low define; low = reset, rising edge captures mode word |
| aux_word | input | MODE_W | Mode word source |
| in_en_n | input | 1 | Input enable: write gate or block start, depending on mode |
| din_stb | input | 1 | Data-input strobe, one sample per rising edge |
| dout_stb | input | 1 | Output strobe, divided internally |
| dump_en_n | input | 1 | Active-low dump enable |
| load_busy | output | 1 | Load-in-progress flag |
| avail_n | output | 1 | Active-low data-available flag |
| wr_en | output | 1 | Workspace write enable, one clock per sample |
| wr_addr | output | ADDR_W | Workspace write address |
| rd_en | output | 1 | Workspace read enable, one clock per result |
| rd_addr | output | ADDR_W | Workspace read address |
| bus_oe | output | 1 | Tri-state enable for the result buses |

## Verification
The hardest situation to reach from the ports is the delayed data-available. It occurs only when three things line up: a block has been loaded in full, the compute count has expired, and exactly the right number of divided output strobes has arrived while the outputs are otherwise silent. The stimulus therefore selects a divide ratio of four together with the delay bit. It fills a block, waits past the compute phase, and issues one raw output strobe short of twenty-four divided ones to show the flag still high. One more strobe must then bring it low.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_HOLD,
    ST_AVAIL
  } xs_state_e;

  // Mode word layout, low six bits of the auxiliary bus
  typedef struct packed {
    logic [1:0] div_sel;    // [5:4] output strobe divide
    logic       delay_en;   // [3]   hold data-available for extra strobes
    logic       start_mode; // [2]   input-enable starts a block
    logic [1:0] rel_sel;    // [1:0] load flag release point
  } xs_mode_t;

  localparam int MODE_BITS = $bits(xs_mode_t);

endpackage

// File: rtl/xs_sync_edge.sv
module xs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  // While held in reset every stage tracks the pin, so no false edge on release
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= {STAGES{raw}};
      last  <= raw;
    end else begin
      chain[0] <= raw;
      last     <= chain[STAGES-1];
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst_n) chain[g] <= chain[g-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
  assign fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/xs_strobe_div.sv
module xs_strobe_div (
  input  logic       clk,
  input  logic       clear,
  input  logic       pulse_in,
  input  logic [1:0] ratio_sel,
  output logic       pulse_out
);
  logic [1:0] phase;
  logic [1:0] last_phase;

  always_comb begin
    case (ratio_sel)
      2'd0:    last_phase = 2'd0;
      2'd1:    last_phase = 2'd1;
      default: last_phase = 2'd3;
    endcase
  end

  assign pulse_out = pulse_in && (phase == last_phase);

  always_ff @(posedge clk) begin
    if (clear)          phase <= '0;
    else if (pulse_out) phase <= '0;
    else if (pulse_in)  phase <= phase + 2'd1;
  end
endmodule

// File: rtl/xform_seq_ctrl.sv
module xform_seq_ctrl
  import xs_pkg::*;
#(
  parameter int BLOCK_LEN      = 256,
  parameter int COMPUTE_CYCLES = 64,
  parameter int OUT_DELAY      = 24,
  parameter int MODE_W         = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int ADDR_W         = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              define_n,
  input  logic [MODE_W-1:0] aux_word,
  input  logic              in_en_n,
  input  logic              din_stb,
  input  logic              dout_stb,
  input  logic              dump_en_n,
  output logic              load_busy,
  output logic              avail_n,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              bus_oe
);
  localparam int CNT_W   = ADDR_W + 1;
  localparam int TMR_MAX = (COMPUTE_CYCLES > OUT_DELAY) ? COMPUTE_CYCLES : OUT_DELAY;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(BLOCK_LEN - 1);
  localparam logic [TMR_W-1:0] CALC_LAST = TMR_W'(COMPUTE_CYCLES - 1);
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(OUT_DELAY - 1);

  xs_state_e        state;
  xs_mode_t         mode;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] release_at;

  logic en_lvl, en_rise, en_fall;
  logic di_lvl, di_rise, di_fall;
  logic do_lvl, do_rise, do_fall;
  logic de_lvl, de_rise, de_fall;
  logic dpulse;
  logic div_clear;

  xs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_en (
    .clk(clk), .rst_n(define_n), .raw(in_en_n),
    .level(en_lvl), .rise(en_rise), .fall(en_fall));
  xs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_di (
    .clk(clk), .rst_n(define_n), .raw(din_stb),
    .level(di_lvl), .rise(di_rise), .fall(di_fall));
  xs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_do (
    .clk(clk), .rst_n(define_n), .raw(dout_stb),
    .level(do_lvl), .rise(do_rise), .fall(do_fall));
  xs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_de (
    .clk(clk), .rst_n(define_n), .raw(dump_en_n),
    .level(de_lvl), .rise(de_rise), .fall(de_fall));

  assign div_clear = !define_n || !((state == ST_HOLD) || (state == ST_AVAIL));

  xs_strobe_div u_div (
    .clk(clk), .clear(div_clear), .pulse_in(do_rise),
    .ratio_sel(mode.div_sel), .pulse_out(dpulse));

  // Load flag release point
  always_comb begin
    case (mode.rel_sel)
      2'd1:    release_at = CNT_W'(BLOCK_LEN / 2);
      2'd2:    release_at = CNT_W'(BLOCK_LEN / 4);
      default: release_at = CNT_W'(BLOCK_LEN);
    endcase
  end

  assign wr_en     = (state == ST_LOAD) && di_rise && (mode.start_mode || !en_lvl);
  assign load_busy = (state == ST_LOAD) && (cnt < release_at);
  assign avail_n   = (state != ST_AVAIL);
  assign bus_oe    = (state == ST_AVAIL) && !de_lvl;
  assign rd_en     = bus_oe && dpulse;
  assign wr_addr   = cnt[ADDR_W-1:0];
  assign rd_addr   = cnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!define_n) begin
      state <= ST_IDLE;
      mode  <= '0;
      armed <= 1'b0;
      cnt   <= '0;
      tmr   <= '0;
    end else begin
      armed <= 1'b1;
      if (!armed) begin
        mode <= xs_mode_t'(aux_word[MODE_BITS-1:0]);
      end else begin
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (mode.start_mode ? en_fall : !en_lvl) state <= ST_LOAD;
          end
          ST_LOAD: begin
            if (wr_en) begin
              if (cnt == LAST_IDX) begin
                cnt   <= '0;
                tmr   <= '0;
                state <= ST_CALC;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_CALC: begin
            if (tmr == CALC_LAST) begin
              tmr   <= '0;
              state <= mode.delay_en ? ST_HOLD : ST_AVAIL;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_HOLD: begin
            if (dpulse) begin
              if (tmr == HOLD_LAST) begin
                tmr   <= '0;
                state <= ST_AVAIL;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          ST_AVAIL: begin
            if (rd_en) begin
              if (cnt == LAST_IDX) begin
                cnt   <= '0;
                state <= ST_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              define_n,
  input logic              load_busy,
  input logic              avail_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              bus_oe
);
  p_wr_step_r4: assert property (@(posedge clk) disable iff (!define_n)
    wr_en |=> (wr_addr == $past(wr_addr) + 1'b1));

  p_rd_step_r9: assert property (@(posedge clk) disable iff (!define_n)
    rd_en |=> (rd_addr == $past(rd_addr) + 1'b1));

  p_busy_excl_r5: assert property (@(posedge clk) disable iff (!define_n)
    load_busy |-> avail_n);

  p_oe_needs_avail_r8: assert property (@(posedge clk) disable iff (!define_n)
    bus_oe |-> !avail_n);

  p_rd_needs_oe_r8: assert property (@(posedge clk) disable iff (!define_n)
    rd_en |-> bus_oe);

  p_no_wr_in_dump_r6: assert property (@(posedge clk) disable iff (!define_n)
    wr_en |-> (avail_n && !rd_en));
endmodule

bind xform_seq_ctrl xs_checker #(.ADDR_W(ADDR_W)) u_xs_checker (
  .clk(clk), .define_n(define_n), .load_busy(load_busy), .avail_n(avail_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
  .bus_oe(bus_oe));

// File: tb/xform_seq_ctrl_bench.sv
`timescale 1ns/1ps
module xform_seq_ctrl_bench;
  localparam int N     = 16;
  localparam int CALC  = 20;
  localparam int AW    = $clog2(N);

  logic          clk = 1'b0;
  logic          define_n = 1'b0;
  logic [15:0]   aux_word = '0;
  logic          in_en_n = 1'b1;
  logic          din_stb = 1'b0;
  logic          dout_stb = 1'b0;
  logic          dump_en_n = 1'b0;
  logic          load_busy, avail_n, wr_en, rd_en, bus_oe;
  logic [AW-1:0] wr_addr, rd_addr;

  int n_cmp = 0, n_bad = 0;
  int wr_seen = 0, wr_err = 0, rd_seen = 0, rd_err = 0;
  logic [AW-1:0] exp_wa = '0, exp_ra = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xform_seq_ctrl #(.BLOCK_LEN(N), .COMPUTE_CYCLES(CALC)) u_xform_seq_ctrl (
    .clk(clk), .define_n(define_n), .aux_word(aux_word), .in_en_n(in_en_n),
    .din_stb(din_stb), .dout_stb(dout_stb), .dump_en_n(dump_en_n),
    .load_busy(load_busy), .avail_n(avail_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .bus_oe(bus_oe));

  // Event monitor on the falling edge
  always @(negedge clk) begin
    if (define_n && wr_en) begin
      if (wr_addr !== exp_wa) wr_err++;
      exp_wa = wr_addr + 1'b1;
      wr_seen++;
    end
    if (define_n && rd_en) begin
      if (rd_addr !== exp_ra) rd_err++;
      exp_ra = rd_addr + 1'b1;
      rd_seen++;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    wr_seen = 0; wr_err = 0; rd_seen = 0; rd_err = 0;
    exp_wa = '0; exp_ra = '0;
  endtask

  task automatic do_define(input logic [15:0] w);
    define_n = 1'b0;
    aux_word = w;
    tick(4);
    define_n = 1'b1;
    tick(3);
    clr_mon();
  endtask

  task automatic pulse_in(input int n);
    for (int i = 0; i < n; i++) begin
      din_stb = 1'b1; tick(4);
      din_stb = 1'b0; tick(4);
    end
  endtask

  task automatic pulse_out(input int n);
    for (int i = 0; i < n; i++) begin
      dout_stb = 1'b1; tick(4);
      dout_stb = 1'b0; tick(4);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    define_n = 1'b0;
    din_stb = 1'b0; dout_stb = 1'b0; in_en_n = 1'b0; dump_en_n = 1'b0;
    tick(5);
    @(negedge clk);
    chk("R1 load_busy", load_busy, 0);
    chk("R1 avail_n", avail_n, 1);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 rd_en", rd_en, 0);
    chk("R1 bus_oe", bus_oe, 0);
    tick(1);
  endtask

  // Gate mode, full release, divide 1, automatic dump
  task automatic t_gate_full();
    in_en_n = 1'b1; dump_en_n = 1'b0;
    do_define(16'h0000);
    pulse_in(3);
    chk("R2 gated strobes ignored", wr_seen, 0);
    in_en_n = 1'b0;
    tick(4);
    chk("R5 busy on load open", load_busy, 1);
    pulse_in(N - 1);
    chk("R5 full release still busy", load_busy, 1);
    pulse_in(1);
    chk("R5 full release dropped", load_busy, 0);
    chk("R4 write count", wr_seen, N);
    chk("R4 write order", wr_err, 0);
    chk("R6 not yet available", avail_n, 1);
    tick(CALC + 4);
    chk("R6 available after compute", avail_n, 0);
    chk("R8 auto dump enables bus", bus_oe, 1);
    pulse_out(N - 1);
    chk("R9 still available", avail_n, 0);
    pulse_out(1);
    chk("R9 read count", rd_seen, N);
    chk("R9 read order", rd_err, 0);
    chk("R9 avail released", avail_n, 1);
    chk("R10 ratio 1", rd_seen, N);
  endtask

  // Start mode, quarter release, divide 2, gated dump
  task automatic t_start_quarter();
    in_en_n = 1'b0; dump_en_n = 1'b1;
    do_define(16'h0016);
    pulse_in(2);
    chk("R3 no write before start edge", wr_seen, 0);
    in_en_n = 1'b1; tick(4);
    in_en_n = 1'b0; tick(4);
    in_en_n = 1'b1;
    pulse_in(N / 4 - 1);
    chk("R5 quarter still busy", load_busy, 1);
    pulse_in(1);
    chk("R5 quarter released", load_busy, 0);
    pulse_in(N - N / 4);
    chk("R3 writes with in_en high", wr_seen, N);
    chk("R4 write order start mode", wr_err, 0);
    tick(CALC + 4);
    chk("R6 available", avail_n, 0);
    chk("R8 bus off while dump disabled", bus_oe, 0);
    pulse_out(4);
    chk("R8 no read while dump disabled", rd_seen, 0);
    dump_en_n = 1'b0;
    tick(4);
    chk("R8 bus on after dump enable", bus_oe, 1);
    pulse_out(1);
    chk("R10 ratio 2 first edge dropped", rd_seen, 0);
    pulse_out(1);
    chk("R10 ratio 2 second edge reads", rd_seen, 1);
    pulse_out(2 * N - 2);
    chk("R9 read count ratio 2", rd_seen, N);
    chk("R9 read order ratio 2", rd_err, 0);
    chk("R9 avail released", avail_n, 1);
  endtask

  // Gate mode, half release, delayed availability, divide 4
  task automatic t_delay_half();
    in_en_n = 1'b1; dump_en_n = 1'b0;
    do_define(16'h0029);
    in_en_n = 1'b0; tick(4);
    pulse_in(N / 2 - 1);
    chk("R5 half still busy", load_busy, 1);
    pulse_in(1);
    chk("R5 half released", load_busy, 0);
    pulse_in(N / 2);
    chk("R4 write count half mode", wr_seen, N);
    tick(CALC + 4);
    chk("R7 held after compute", avail_n, 1);
    pulse_out(24 * 4 - 1);
    chk("R7 held one strobe short", avail_n, 1);
    chk("R8 bus off during delay", bus_oe, 0);
    pulse_out(1);
    chk("R7 available after delay", avail_n, 0);
    chk("R7 no reads during delay", rd_seen, 0);
    pulse_out(3);
    chk("R10 ratio 4 three edges", rd_seen, 0);
    pulse_out(1);
    chk("R10 ratio 4 fourth edge", rd_seen, 1);
    pulse_out(4 * N - 4);
    chk("R9 read count ratio 4", rd_seen, N);
    chk("R9 read order ratio 4", rd_err, 0);
    chk("R9 avail released", avail_n, 1);
  endtask

  initial begin
    t_reset();
    t_gate_full();
    t_start_quarter();
    t_delay_half();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule